// File: doc/BRIEF.md
# Three-Channel Offset Trim Calibrator

This block removes the output offset of three video amplifier channels. Each channel owns a 7-bit offset DAC: code 0x00 applies the strongest negative correction (roughly -400 mV at the output) and 0x7F the strongest positive one (roughly +400 mV). When software sets the calibration start bit, the block runs a successive-approximation search on all three DAC codes at once. For each channel a comparator reports whether the amplifier output lies above its reference. Once the last bit is decided, the block clears the start bit and raises a one-cycle done pulse.

During a run the block can short the amplifier inputs to each other, so that only the internal offset is measured. It can also leave them connected, so that offsets from the external system are trimmed as well. A separate short request forces the inputs shorted at any time. Each channel has a manual override that drives its DAC straight from a register code instead of from the calibrated result.

The settle time of each search step can be programmed. A full run takes 7 steps. At a 250 MHz clock, a settle value of 106 or less keeps the whole run within about 3 µs. The offset is undefined until the first calibration, and a run should be repeated after any gain or filter change.

Top module: `trim_sar_cal`

## Requirements
- R1: After reset, startBit and calDone are 0 and every channel's calibrated code is 0x40, so each channel without manual override shows 0x40 on dacCode. Channel c occupies dacCode[7c+6:7c] (channel 0 red, 1 green, 2 blue).
- R2: startReq held high across one rising edge while idle starts a run, and startBit reads 1 from that edge on.
- R3: All three channels are searched independently in parallel. When the comparator reports high exactly when a channel's code exceeds a fixed target T in 0..127, that channel's calibrated code after the run equals T.
- R4: A run lasts exactly 7*(settleCycles+1) clock cycles, counted from the accepting edge to the edge that clears startBit.
- R5: startBit falls on the same edge that raises calDone, and calDone stays high for exactly one cycle.
- R6: startReq asserted while a run is in progress is ignored: the run length and the results are unchanged.
- R7: With forceShort at 0, inputShort is 1 during a run when calMode is 0 and 0 when calMode is 1. It is 0 while idle.
- R8: forceShort at 1 drives inputShort to 1 whether a run is active or not, and whatever the value of calMode.
- R9: When manualSel[c] is 1, channel c's dacCode is its manualCode field, and a run that ends with that bit set leaves the channel's calibrated code unchanged. When manualSel[c] is 0, the manualCode field has no effect and the last calibrated code is shown.
- R10: The search is MSB first. On the cycle after the accepting edge, every channel without manual override shows trial code 0x40 on dacCode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| startReq | input | 1 | Write of 1 to the start bit |
| calMode | input | 1 | 1 keeps the inputs connected during a run |
| forceShort | input | 1 | 1 shorts the inputs unconditionally |
| settleCycles | input | 7 | Extra wait cycles per search step |
| manualSel | input | 3 | Per-channel manual override enable |
| manualCode | input | 21 | Per-channel manual DAC codes, 7 bits each |
| cmpHigh | input | 3 | Per-channel comparator, 1 = output above reference |
| startBit | output | 1 | Start bit readback, cleared at the end of a run |
| calDone | output | 1 | One-cycle pulse when a run ends |
| inputShort | output | 1 | Input shorting switch control |
| dacCode | output | 21 | Per-channel offset DAC codes applied |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of a settle window, when the controller is neither idle nor at a decision point. The bench raises startReq part way through a long run and confirms that both the cycle count and the three searched codes match a run without the extra request. A behavioural comparator closes the loop on the DAC outputs, so every search converges to a random target. The bench also uses directed targets at 0, 63, 64 and 127 to reach both ends of the code range.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
  typedef struct packed {
    logic launch;  // accepted start: load MSB trial
    logic decide;  // sample comparator for current bit
    logic finish;  // last bit decided this cycle
  } calStrobe_t;
endpackage

// File: rtl/trim_cal_ctrl.sv
module trim_cal_ctrl
  import trim_cal_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int SETTLE_W = 7,
  localparam int IDX_W   = $clog2(CODE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startReq,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                busy,
  output logic                calDone,
  output logic [IDX_W-1:0]    bitIdx,
  output calStrobe_t          stb
);
  logic [SETTLE_W-1:0] settleCnt;

  always_comb begin
    stb.launch = !busy && startReq;
    stb.decide = busy && (settleCnt == '0);
    stb.finish = stb.decide && (bitIdx == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      calDone   <= 1'b0;
      bitIdx    <= '0;
      settleCnt <= '0;
    end else begin
      calDone <= 1'b0;
      if (stb.launch) begin
        busy      <= 1'b1;
        bitIdx    <= IDX_W'(CODE_W - 1);
        settleCnt <= settleCycles;
      end else if (busy) begin
        if (settleCnt != '0) begin
          settleCnt <= settleCnt - 1'b1;
        end else if (bitIdx == '0) begin
          busy    <= 1'b0;
          calDone <= 1'b1;
        end else begin
          bitIdx    <= bitIdx - 1'b1;
          settleCnt <= settleCycles;
        end
      end
    end
  end

  // R4: a step still settling cannot end the run
  assert_settle_holds_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && settleCnt != '0) |=> busy);
  // R5: start bit only clears together with the done pulse
  assert_fall_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> calDone);
  // R5: done is a single-cycle pulse
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    calDone |=> !calDone);
endmodule

// File: rtl/trim_cal_path.sv
module trim_cal_path
  import trim_cal_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CODE_W = 7,
  localparam int IDX_W = $clog2(CODE_W),
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  calStrobe_t              stb,
  input  logic                    busy,
  input  logic [IDX_W-1:0]        bitIdx,
  input  logic [NCH-1:0]          cmpHigh,
  input  logic [NCH-1:0]          manualSel,
  input  logic [NCH*CODE_W-1:0]   manualCode,
  output logic [NCH*CODE_W-1:0]   dacCode
);
  logic [CODE_W-1:0] curMask, nextMask;

  always_comb begin
    curMask  = CODE_W'(1) << bitIdx;
    nextMask = (bitIdx == '0) ? '0 : (curMask >> 1);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CODE_W-1:0] trialCode, autoCode, resolved, regCode;

    assign regCode  = manualCode[c*CODE_W +: CODE_W];
    assign resolved = cmpHigh[c] ? (trialCode & ~curMask) : trialCode;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trialCode <= MID;
        autoCode  <= MID;
      end else begin
        if (stb.launch)      trialCode <= MID;
        else if (stb.decide) trialCode <= resolved | nextMask;
        if (stb.finish && !manualSel[c]) autoCode <= resolved;
      end
    end

    assign dacCode[c*CODE_W +: CODE_W] =
      manualSel[c] ? regCode : (busy ? trialCode : autoCode);

    // R10: each run opens with the MSB trial
    assert_msb_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> trialCode == MID);
    // R9: while idle with stable override settings the DAC code holds
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && $stable(manualSel[c]) && $stable(regCode))
        |-> $stable(dacCode[c*CODE_W +: CODE_W]));
  end
endmodule

// File: rtl/trim_sar_cal.sv
module trim_sar_cal
  import trim_cal_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int CODE_W   = 7,
  parameter int SETTLE_W = 7,
  localparam int IDX_W   = $clog2(CODE_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  startReq,
  input  logic                  calMode,
  input  logic                  forceShort,
  input  logic [SETTLE_W-1:0]   settleCycles,
  input  logic [NCH-1:0]        manualSel,
  input  logic [NCH*CODE_W-1:0] manualCode,
  input  logic [NCH-1:0]        cmpHigh,
  output logic                  startBit,
  output logic                  calDone,
  output logic                  inputShort,
  output logic [NCH*CODE_W-1:0] dacCode
);
  logic             busy;
  logic [IDX_W-1:0] bitIdx;
  calStrobe_t       stb;

  trim_cal_ctrl #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .settleCycles(settleCycles),
    .busy(busy), .calDone(calDone), .bitIdx(bitIdx), .stb(stb)
  );

  trim_cal_path #(.NCH(NCH), .CODE_W(CODE_W)) path_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .busy(busy), .bitIdx(bitIdx),
    .cmpHigh(cmpHigh), .manualSel(manualSel), .manualCode(manualCode),
    .dacCode(dacCode)
  );

  assign startBit   = busy;
  assign inputShort = forceShort | (busy & ~calMode);

  // R8: a forced short is never overridden by the calibration state
  assert_force_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (forceShort && $past(calDone)) |-> inputShort);
endmodule

// File: tb/trim_sar_cal_tb_top.sv
module trim_sar_cal_tb_top;
  localparam int NCH = 3, CW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic startReq = 1'b0, calMode = 1'b0, forceShort = 1'b0;
  logic [6:0] settleCycles = '0;
  logic [2:0] manualSel = '0;
  logic [20:0] manualCode = '0;
  logic [2:0] cmpHigh;
  logic startBit, calDone, inputShort;
  logic [20:0] dacCode;

  logic [6:0] target [NCH];
  logic [6:0] expAuto [NCH];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  trim_sar_cal dut_i (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .calMode(calMode),
    .forceShort(forceShort), .settleCycles(settleCycles), .manualSel(manualSel),
    .manualCode(manualCode), .cmpHigh(cmpHigh), .startBit(startBit),
    .calDone(calDone), .inputShort(inputShort), .dacCode(dacCode)
  );

  // behavioural comparator: output above reference when code exceeds target
  always_comb
    for (int c = 0; c < NCH; c++) cmpHigh[c] = dacCode[c*CW +: CW] > target[c];

  function automatic logic [6:0] chCode(input int c);
    return dacCode[c*CW +: CW];
  endfunction

  function automatic logic [6:0] expDac(input int c);
    return manualSel[c] ? manualCode[c*CW +: CW] : expAuto[c];
  endfunction

  function automatic int expLen(input int s);
    return 7 * (s + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one calibration run; optional extra start in mid-run
  task automatic runCal(input int s, input bit extraStart);
    int len;
    bit shortOk;
    settleCycles = 7'(s);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(startBit == 1'b1, "R2", startBit, 1);
    for (int c = 0; c < NCH; c++)
      if (!manualSel[c]) chk(chCode(c) == 7'h40, "R10", chCode(c), 'h40);
    len = 0;
    shortOk = 1'b1;
    while (startBit && len < 2000) begin
      len++;
      startReq = (extraStart && len == expLen(s) / 2);
      if (inputShort != (forceShort | ~calMode)) shortOk = 1'b0;
      @(negedge clk);
    end
    startReq = 1'b0;
    chk(shortOk, forceShort ? "R8" : "R7", inputShort, forceShort | ~calMode);
    chk(len == expLen(s), extraStart ? "R6" : "R4", len, expLen(s));
    chk(calDone == 1'b1, "R5", calDone, 1);
    for (int c = 0; c < NCH; c++) if (!manualSel[c]) expAuto[c] = target[c];
    for (int c = 0; c < NCH; c++)
      chk(chCode(c) == expDac(c), manualSel[c] ? "R9" : "R3", chCode(c), expDac(c));
    @(negedge clk);
    chk(calDone == 1'b0, "R5", calDone, 0);
    chk(inputShort == forceShort, forceShort ? "R8" : "R7", inputShort, forceShort);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < NCH; c++) begin target[c] = 7'h40; expAuto[c] = 7'h40; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(startBit == 1'b0, "R1", startBit, 0);
    chk(calDone == 1'b0, "R1", calDone, 0);
    for (int c = 0; c < NCH; c++) chk(chCode(c) == 7'h40, "R1", chCode(c), 'h40);

    // directed corners, R3
    target[0] = 7'h00; target[1] = 7'h7F; target[2] = 7'h3F;
    runCal(0, 1'b0);
    target[0] = 7'h40; target[1] = 7'h00; target[2] = 7'h7F;
    calMode = 1'b1;
    runCal(3, 1'b0);
    // R6: start during a run, longest settle that fits the budget
    target[0] = 7'h15; target[1] = 7'h6A; target[2] = 7'h01;
    runCal(106, 1'b1);

    // R8: forced short while idle and during a run with calMode 1
    forceShort = 1'b1;
    @(negedge clk);
    chk(inputShort == 1'b1, "R8", inputShort, 1);
    runCal(2, 1'b0);
    forceShort = 1'b0;

    // R9: manual override on channel 1
    manualSel = 3'b010;
    manualCode = {7'h11, 7'h2B, 7'h55};
    @(negedge clk);
    chk(chCode(1) == 7'h2B, "R9", chCode(1), 'h2B);
    chk(chCode(0) == expAuto[0], "R9", chCode(0), expAuto[0]);
    target[0] = 7'h33; target[1] = 7'h0C; target[2] = 7'h5E;
    calMode = 1'b0;
    runCal(1, 1'b0);
    manualSel = 3'b000;
    @(negedge clk);
    chk(chCode(1) == expAuto[1], "R9", chCode(1), expAuto[1]);

    // random rounds, R3 and R4
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < NCH; c++) target[c] = 7'($urandom_range(0, 127));
      calMode = 1'($urandom_range(0, 1));
      manualCode = 21'($urandom);
      runCal($urandom_range(0, 20), r == 5);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule